// File: doc/BRIEF.md
# SPI Register-Message Bridge to Word Memory

This block lets a host microcontroller on an SPI link load, inspect and drain a word-organised memory that holds a virtual disk image. It also lets the host set a few control lines and read back drive status. Every SPI transaction carries exactly two bytes. The first byte names a register and the second carries one data byte. The top bit of the register byte sets the direction: when it is set, the host reads a byte back on MISO during the second byte of the same transaction.

A memory address wider than a byte is built from repeated writes to the address register, with the most significant byte first. A data word is built the same way from repeated writes to the write-data register. When the last byte of a word arrives, the word is written to memory and the address then advances by one. A pair of reads from the read-data register returns one word, high byte first, and the address advances after the pair. The memory side is a simple request/acknowledge port: a request stays asserted, with its address and data held, until the memory acknowledges it. All SPI pins are synchronised into the system clock domain. SCLK must therefore be several times slower than the system clock. A memory read must also be acknowledged within about half an SCLK period.

Top module: `spi_mem_bridge`

## Requirements
- R1: Pulling `spi_cs_n` high before a message's 16th SCLK rising edge discards that message with no effect. The next message after CS goes low again is framed from its first bit.
- R2: A register byte with bit 7 set is a read. A read never changes the control outputs or memory state, and a read of an undefined register returns 0x00.
- R3: A write of register 0x00 sets `cart_ready` from data bit 0 and `fault_latch` from data bit 1.
- R4: A write of register 0x04 inverts `write_protect`, whatever the data byte is.
- R5: Three successive writes of register 0x05 load the 24-bit memory address, most significant byte first.
- R6: Two successive writes of register 0x06 form a 16-bit word, high byte first. After the second byte, a memory write of that word is issued at the current address.
- R7: Each acknowledged memory write advances the address by one, with carry across byte boundaries.
- R8: Two successive reads of register 0x88 return the word at the current address, high byte then low byte, on MISO. The address advances by one after the pair.
- R9: A read of register 0xA0 returns drive_unlocked in bit 0, cart_ready in bit 1, disk_fault in bit 2 and disk_ready in bit 3, with bits 7 to 4 zero.
- R10: After reset, `cart_ready`, `fault_latch`, `write_protect`, `mem_wr` and `mem_rd` are all low.
- R11: A memory request holds its strobe, address and write data until `mem_ack`, and the read and write strobes are never high together.
- R12: Any completed message to a register other than 0x05 (or 0x06, or 0x88) restarts that register's multi-byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | SPI clock from host, mode 0 |
| spi_mosi | input | 1 | Host-to-block serial data, MSB first |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Block-to-host serial data |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_wr | output | 1 | Write request, held until ack |
| mem_rd | output | 1 | Read request, held until ack |
| mem_rdata | input | DATA_W | Read word, valid with ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| cart_ready | output | 1 | Cartridge-loaded control line |
| fault_latch | output | 1 | Image-fault control line |
| write_protect | output | 1 | Write-protect flag |
| disk_ready | input | 1 | Status: drive at speed |
| disk_fault | input | 1 | Status: drive fault seen |
| drive_unlocked | input | 1 | Status: drive stopped and unlocked |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 16-bit word and two synchroniser stages. It uses an SCLK half-period of ten system clocks. The full three-byte address path is therefore exercised, including the carry from 0x00FFFF to 0x010000 on auto-increment. The two-byte word split and the timing of a memory read completing before the reply byte is shifted out are also within reach. A memory model that acknowledges after a short delay exposes whether requests are held correctly.

// File: rtl/spibr_pkg.sv
package spibr_pkg;
    localparam logic [7:0] REG_CTRL  = 8'h00;
    localparam logic [7:0] REG_PROT  = 8'h04;
    localparam logic [7:0] REG_ADDR  = 8'h05;
    localparam logic [7:0] REG_WDATA = 8'h06;
    localparam logic [7:0] REG_RDATA = 8'h88;
    localparam logic [7:0] REG_STAT  = 8'hA0;

    localparam int ST_UNLOCK = 0;
    localparam int ST_CART   = 1;
    localparam int ST_FAULT  = 2;
    localparam int ST_READY  = 3;

    typedef struct packed {
        logic       sclk;
        logic [2:0] cnt;
        logic [1:0] idx;
        logic [7:0] rx;
        logic [7:0] tx;
        logic       vld;
        logic       first;
        logic [7:0] data;
    } byte_st_t;
endpackage

// File: rtl/spibr_sync.sv
module spibr_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= RST_VAL;
                else     chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spibr_byte.sv
module spibr_byte
    import spibr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       csn_s,
    input  logic [7:0] reply,
    output logic       byte_vld,
    output logic       byte_first,
    output logic [7:0] byte_data,
    output logic       miso
);
    byte_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.sclk = sclk_s;
        if (csn_s) begin
            st_d.cnt = '0;
            st_d.idx = '0;
            st_d.tx  = '0;
        end else if (sclk_s && !st_q.sclk) begin
            st_d.rx  = {st_q.rx[6:0], mosi_s};
            st_d.cnt = st_q.cnt + 3'd1;
            if (st_q.cnt == 3'd7 && st_q.idx != 2'd2) begin
                st_d.vld   = 1'b1;
                st_d.first = (st_q.idx == 2'd0);
                st_d.data  = {st_q.rx[6:0], mosi_s};
                st_d.idx   = st_q.idx + 2'd1;
            end
        end else if (!sclk_s && st_q.sclk) begin
            if (st_q.cnt == 3'd0 && st_q.idx == 2'd1) st_d.tx = reply;
            else                                      st_d.tx = {st_q.tx[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign byte_vld   = st_q.vld;
    assign byte_first = st_q.first;
    assign byte_data  = st_q.data;
    assign miso       = st_q.tx[7];
endmodule

// File: rtl/spibr_decode.sv
module spibr_decode
    import spibr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic              byte_first,
    input  logic [7:0]        byte_data,
    output logic [7:0]        reply,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              cart_ready,
    output logic              fault_latch,
    output logic              write_protect,
    input  logic              disk_ready,
    input  logic              disk_fault,
    input  logic              drive_unlocked
);
    localparam int AB  = ADDR_W / 8;
    localparam int DB  = DATA_W / 8;
    localparam int ACW = (AB > 1) ? $clog2(AB) : 1;
    localparam int DCW = (DB > 1) ? $clog2(DB) : 1;

    typedef struct packed {
        logic [7:0]        regn;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] astage;
        logic [ACW-1:0]    acnt;
        logic [DATA_W-1:0] wstage;
        logic [DCW-1:0]    wcnt;
        logic [DATA_W-1:0] rbuf;
        logic [DCW-1:0]    rcnt;
        logic [7:0]        reply;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              rd;
        logic              cart;
        logic              fault;
        logic              prot;
    } dec_t;

    dec_t s_q, s_d;

    logic [7:0] status_byte;
    assign status_byte = {4'b0000, disk_ready, disk_fault, s_q.cart, drive_unlocked};

    always_comb begin
        s_d = s_q;
        if (s_q.wr && mem_ack) begin
            s_d.wr   = 1'b0;
            s_d.addr = s_q.addr + 1'b1;
        end
        if (s_q.rd && mem_ack) begin
            s_d.rd    = 1'b0;
            s_d.rbuf  = mem_rdata;
            s_d.reply = mem_rdata[DATA_W-1 -: 8];
        end
        if (byte_vld && byte_first) begin
            s_d.regn  = byte_data;
            s_d.reply = 8'h00;
            if (byte_data == REG_STAT) s_d.reply = status_byte;
            if (byte_data == REG_RDATA) begin
                if (s_q.rcnt == '0) s_d.rd    = 1'b1;
                else                s_d.reply = s_q.rbuf[DATA_W-1 -: 8];
            end
        end
        if (byte_vld && !byte_first) begin
            if (s_q.regn != REG_ADDR)  s_d.acnt = '0;
            if (s_q.regn != REG_WDATA) s_d.wcnt = '0;
            if (s_q.regn != REG_RDATA) s_d.rcnt = '0;
            case (s_q.regn)
                REG_CTRL: begin
                    s_d.cart  = byte_data[0];
                    s_d.fault = byte_data[1];
                end
                REG_PROT: s_d.prot = ~s_q.prot;
                REG_ADDR: begin
                    s_d.astage = {s_q.astage[ADDR_W-9:0], byte_data};
                    if (s_q.acnt == ACW'(AB-1)) begin
                        s_d.addr = {s_q.astage[ADDR_W-9:0], byte_data};
                        s_d.acnt = '0;
                    end else begin
                        s_d.acnt = s_q.acnt + 1'b1;
                    end
                end
                REG_WDATA: begin
                    s_d.wstage = {s_q.wstage[DATA_W-9:0], byte_data};
                    if (s_q.wcnt == DCW'(DB-1)) begin
                        s_d.wdata = {s_q.wstage[DATA_W-9:0], byte_data};
                        s_d.wr    = 1'b1;
                        s_d.wcnt  = '0;
                    end else begin
                        s_d.wcnt = s_q.wcnt + 1'b1;
                    end
                end
                REG_RDATA: begin
                    if (s_q.rcnt == DCW'(DB-1)) begin
                        s_d.rcnt = '0;
                        s_d.addr = s_q.addr + 1'b1;
                    end else begin
                        s_d.rcnt = s_q.rcnt + 1'b1;
                        s_d.rbuf = {s_q.rbuf[DATA_W-9:0], 8'h00};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign reply         = s_q.reply;
    assign mem_addr      = s_q.addr;
    assign mem_wdata     = s_q.wdata;
    assign mem_wr        = s_q.wr;
    assign mem_rd        = s_q.rd;
    assign cart_ready    = s_q.cart;
    assign fault_latch   = s_q.fault;
    assign write_protect = s_q.prot;
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              cart_ready,
    output logic              fault_latch,
    output logic              write_protect,
    input  logic              disk_ready,
    input  logic              disk_fault,
    input  logic              drive_unlocked
);
    logic [2:0] pins_s;
    logic       bvld, bfirst;
    logic [7:0] bdata, reply;

    spibr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout(pins_s)
    );

    spibr_byte u_byte (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .csn_s     (pins_s[2]),
        .reply     (reply),
        .byte_vld  (bvld),
        .byte_first(bfirst),
        .byte_data (bdata),
        .miso      (spi_miso)
    );

    spibr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk           (clk),
        .rst           (rst),
        .byte_vld      (bvld),
        .byte_first    (bfirst),
        .byte_data     (bdata),
        .reply         (reply),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_wr        (mem_wr),
        .mem_rd        (mem_rd),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .cart_ready    (cart_ready),
        .fault_latch   (fault_latch),
        .write_protect (write_protect),
        .disk_ready    (disk_ready),
        .disk_fault    (disk_fault),
        .drive_unlocked(drive_unlocked)
    );
endmodule

// File: rtl/spibr_chk.sv
module spibr_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_ack,
    input logic              cart_ready,
    input logic              fault_latch,
    input logic              write_protect
);
    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr && !mem_ack |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

    // R11
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr, mem_rd}));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cart_ready && !fault_latch && !write_protect && !mem_wr && !mem_rd);

    // R4
    prot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || mem_rd) |=> $stable(write_protect) || !(mem_wr || mem_rd) || mem_ack);
endmodule

bind spi_mem_bridge spibr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wr       (mem_wr),
    .mem_rd       (mem_rd),
    .mem_ack      (mem_ack),
    .cart_ready   (cart_ready),
    .fault_latch  (fault_latch),
    .write_protect(write_protect)
);

// File: tb/spi_mem_bridge_tb.sv
module spi_mem_bridge_tb;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_wr, mem_rd, mem_ack = 1'b0;
    logic        cart_ready, fault_latch, write_protect;
    logic        disk_ready = 1'b0, disk_fault = 1'b0, drive_unlocked = 1'b0;

    int checks = 0, fails = 0, lat = 0, wr_count = 0;
    logic [23:0] last_wa;
    logic [15:0] last_wd;
    bit          finished = 0;

    always #5 clk = ~clk;

    spi_mem_bridge u_dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cart_ready(cart_ready), .fault_latch(fault_latch), .write_protect(write_protect),
        .disk_ready(disk_ready), .disk_fault(disk_fault), .drive_unlocked(drive_unlocked)
    );

    assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if ((mem_wr || mem_rd) && !mem_ack) begin
            if (lat == 2) begin
                mem_ack <= 1'b1;
                lat     <= 0;
                if (mem_wr) begin
                    last_wa  <= mem_addr;
                    last_wd  <= mem_wdata;
                    wr_count <= wr_count + 1;
                end
            end else lat <= lat + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_msg(input logic [7:0] r, input logic [7:0] d, output logic [7:0] got,
                           input int stop_bits = 16);
        logic [15:0] frame = {r, d};
        got = 8'h00;
        @(negedge clk);
        cs_n = 1'b0;
        clocks(HALF);
        for (int i = 0; i < stop_bits; i++) begin
            mosi = frame[15-i];
            clocks(HALF);
            if (i >= 8) got = {got[6:0], miso};
            sclk = 1'b1;
            clocks(HALF);
            sclk = 1'b0;
        end
        clocks(HALF);
        cs_n = 1'b1;
        clocks(3 * HALF);
    endtask

    task automatic send(input logic [7:0] r, input logic [7:0] d);
        logic [7:0] g;
        spi_msg(r, d, g);
    endtask

    task automatic t_reset();
        chk("R10 cart_ready", cart_ready, 0);
        chk("R10 fault_latch", fault_latch, 0);
        chk("R10 write_protect", write_protect, 0);
        chk("R10 mem strobes", {mem_wr, mem_rd}, 0);
    endtask

    task automatic t_ctrl();
        send(8'h00, 8'h03);
        chk("R3 cart/fault set", {cart_ready, fault_latch}, 2'b11);
        send(8'h00, 8'h01);
        chk("R3 fault cleared", {cart_ready, fault_latch}, 2'b10);
    endtask

    task automatic t_dir();
        logic [7:0] g;
        spi_msg(8'h80, 8'h02, g);
        chk("R2 read leaves controls", {cart_ready, fault_latch}, 2'b10);
        chk("R2 undefined read returns zero", g, 8'h00);
    endtask

    task automatic t_prot();
        send(8'h04, 8'h00);
        chk("R4 toggle on", write_protect, 1);
        send(8'h04, 8'hFF);
        chk("R4 toggle off", write_protect, 0);
    endtask

    task automatic t_status();
        logic [7:0] g;
        disk_ready = 1'b1; disk_fault = 1'b0; drive_unlocked = 1'b1;
        spi_msg(8'hA0, 8'h00, g);
        chk("R9 status pattern A", g, 8'h0B);
        send(8'h00, 8'h00);
        disk_ready = 1'b0; disk_fault = 1'b1; drive_unlocked = 1'b0;
        spi_msg(8'hA0, 8'h00, g);
        chk("R9 status pattern B", g, 8'h04);
    endtask

    task automatic t_write();
        int n0 = wr_count;
        send(8'h05, 8'h12); send(8'h05, 8'h34); send(8'h05, 8'h56);
        send(8'h06, 8'hAB); send(8'h06, 8'hCD);
        chk("R5 write address", last_wa, 24'h123456);
        chk("R6 write word", last_wd, 16'hABCD);
        send(8'h06, 8'h11); send(8'h06, 8'h22);
        chk("R7 next address", last_wa, 24'h123457);
        chk("R6 second word", last_wd, 16'h1122);
        chk("R6 write count", wr_count - n0, 2);
    endtask

    task automatic t_carry();
        send(8'h05, 8'h00); send(8'h05, 8'hFF); send(8'h05, 8'hFF);
        send(8'h06, 8'h01); send(8'h06, 8'h02);
        chk("R7 pre-carry address", last_wa, 24'h00FFFF);
        send(8'h06, 8'h03); send(8'h06, 8'h04);
        chk("R7 carried address", last_wa, 24'h010000);
    endtask

    task automatic t_read();
        logic [7:0] hi, lo;
        send(8'h05, 8'h00); send(8'h05, 8'h02); send(8'h05, 8'h00);
        spi_msg(8'h88, 8'h00, hi);
        spi_msg(8'h88, 8'h00, lo);
        chk("R8 word0", {hi, lo}, 16'hA7C3);
        spi_msg(8'h88, 8'h00, hi);
        spi_msg(8'h88, 8'h00, lo);
        chk("R8 word1 after advance", {hi, lo}, 16'hA7C2);
    endtask

    task automatic t_restart();
        send(8'h05, 8'h12); send(8'h05, 8'h34);
        send(8'h00, 8'h00);
        send(8'h05, 8'h00); send(8'h05, 8'h00); send(8'h05, 8'h40);
        send(8'h06, 8'h77);
        send(8'h04, 8'h00);
        send(8'h06, 8'hBE); send(8'h06, 8'hEF);
        chk("R12 address restarted", last_wa, 24'h000040);
        chk("R12 data restarted", last_wd, 16'hBEEF);
        send(8'h04, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] g;
        send(8'h00, 8'h00);
        spi_msg(8'h00, 8'h03, g, 12);
        chk("R1 aborted message ignored", {cart_ready, fault_latch}, 2'b00);
        send(8'h00, 8'h01);
        chk("R1 framing recovers", {cart_ready, fault_latch}, 2'b10);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        clocks(5);
        rst = 1'b0;
        clocks(2);
        t_reset();
        t_ctrl();
        t_dir();
        t_prot();
        t_status();
        t_write();
        t_carry();
        t_read();
        t_restart();
        t_abort();
        finished = 1;
        report();
    end
endmodule